// File: doc/BRIEF.md
# Multi-Width ALU with Status Flags

This block is the arithmetic and logic stage of an accumulator-style processor whose operands may be 8, 16 or 32 bits wide. Each cycle it takes two operands, a size select, an operation code and a carry input. It returns, without any clock delay, a result cut to the selected size and six status flags computed at that size.

The operations are add and subtract, each with and without the incoming carry, the three bitwise operations, and a one-bit rotate through carry in either direction. One flag position changes meaning with the operation. For arithmetic it reports signed overflow. For logical and rotate operations it reports even parity of the result. The half-carry is taken at the nibble boundary just below the top nibble of the selected size.

A six-bit flag register stores the flags when its write enable is high and keeps them otherwise. The surrounding core decides when an instruction commits its flags.

Top module: `aluFlagUnit`

## Requirements
- R1: `sizeSel` picks the width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. Operand bits above that width are ignored, and result bits above it are 0.
- R2: `opCode` 0 (add) returns A+B, and 1 (add with carry) returns A+B+`carryIn`, both modulo 2^width. Carry (bit 0 of the flag vector) is the carry out of the top bit of the width. `carryIn` has no effect on opcode 0.
- R3: `opCode` 2 (subtract) returns A-B, and 3 (subtract with borrow) returns A-B-`carryIn`, both modulo 2^width. Carry is 1 exactly when a borrow occurs, meaning A is less than B plus the borrow-in. `carryIn` has no effect on opcode 2.
- R4: The subtract flag (bit 1) is 1 for opcodes 2 and 3 and 0 for every other opcode.
- R5: For opcodes 0 to 3, the parity/overflow flag (bit 2) is 1 exactly when the signed two's-complement result at the selected width is out of range.
- R6: For opcodes 4 to 8, the parity/overflow flag is 1 when the sized result has an even number of ones, and 0 when that number is odd.
- R7: For opcodes 0 to 3, the half-carry flag (bit 3) is the carry or borrow into bit 4 at 8 bits, into bit 12 at 16 bits, and into bit 28 at 32 bits. The incoming carry is included for opcodes 1 and 3.
- R8: The zero flag (bit 4) is 1 exactly when the sized result is 0.
- R9: The sign flag (bit 5) equals bit 7, 15 or 31 of the result, following the selected width.
- R10: `opCode` 4 is AND, 5 is OR and 6 is XOR. All three clear carry and the subtract flag. AND sets half-carry, while OR and XOR clear it.
- R11: `opCode` 7 rotates A left through carry: `carryIn` enters bit 0 and the top bit leaves into carry. `opCode` 8 rotates A right through carry: `carryIn` enters the top bit and bit 0 leaves into carry. Both rotates clear half-carry and the subtract flag.
- R12: `flagReg` loads `flagsNow` on a rising clock edge when `flagWrEn` is 1 and holds its value otherwise. A synchronous `rst` clears it to 0, and reset wins over the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| opA | input | 32 | First operand; also the rotate source |
| opB | input | 32 | Second operand |
| sizeSel | input | 2 | Operand width select |
| opCode | input | 4 | Operation code |
| carryIn | input | 1 | Incoming carry for add with carry, subtract with borrow and the rotates |
| flagWrEn | input | 1 | Flag register write enable |
| result | output | 32 | Sized result, zero above the selected width |
| flagsNow | output | 6 | Combinational flags {sign, zero, half, par/ovf, subtract, carry} |
| flagReg | output | 6 | Registered flags, same layout |

## Verification
The datapath holds no state, so a wrong width mask, nibble boundary or borrow polarity shows on `result` and `flagsNow` in the same cycle the inputs are applied. The tests therefore target values at each nibble and sign boundary, at all three widths. The flag register is the only storage. A missed load, a lost hold or a reset that loses to the write enable shows on `flagReg` one clock edge after the stimulus.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DataW = 32;
  localparam int FlagW = 6;

  typedef enum logic [3:0] {
    OpAdd  = 4'd0,
    OpAdc  = 4'd1,
    OpSub  = 4'd2,
    OpSbc  = 4'd3,
    OpAnd  = 4'd4,
    OpOr   = 4'd5,
    OpXor  = 4'd6,
    OpRotL = 4'd7,
    OpRotR = 4'd8
  } opCodeT;

  typedef enum logic [1:0] {
    BitAnd = 2'd0,
    BitOr  = 2'd1,
    BitXor = 2'd2
  } bitOpT;

  // Strobes the control hands to the datapath
  typedef struct packed {
    logic  doArith;
    logic  doSub;
    logic  useCarry;
    logic  doBitwise;
    bitOpT bitOp;
    logic  doRotate;
    logic  rotRight;
  } aluStrobeT;

  // Bit 5 down to bit 0
  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic parOvf;
    logic subtr;
    logic carry;
  } flagT;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [3:0] opCode,
  output aluStrobeT  strobe
);
  always_comb begin
    strobe = '0;
    strobe.bitOp = BitAnd;
    case (opCodeT'(opCode))
      OpAdc: begin
        strobe.doArith  = 1'b1;
        strobe.useCarry = 1'b1;
      end
      OpSub: begin
        strobe.doArith = 1'b1;
        strobe.doSub   = 1'b1;
      end
      OpSbc: begin
        strobe.doArith  = 1'b1;
        strobe.doSub    = 1'b1;
        strobe.useCarry = 1'b1;
      end
      OpAnd: begin
        strobe.doBitwise = 1'b1;
        strobe.bitOp     = BitAnd;
      end
      OpOr: begin
        strobe.doBitwise = 1'b1;
        strobe.bitOp     = BitOr;
      end
      OpXor: begin
        strobe.doBitwise = 1'b1;
        strobe.bitOp     = BitXor;
      end
      OpRotL: strobe.doRotate = 1'b1;
      OpRotR: begin
        strobe.doRotate = 1'b1;
        strobe.rotRight = 1'b1;
      end
      default: strobe.doArith = 1'b1;  // plain add
    endcase
  end

  always_comb begin
    assert_one_class_R4: assert (!(strobe.doSub && !strobe.doArith))
      else $error("subtract strobe without arithmetic class");
  end
endmodule

// File: rtl/aluPath.sv
module aluPath
  import aluPkg::*;
#(
  parameter int DataW = aluPkg::DataW
) (
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [1:0]       sizeSel,
  input  logic             carryIn,
  input  aluStrobeT        strobe,
  output logic [DataW-1:0] result,
  output flagT             flags
);
  localparam int IdxW  = $clog2(DataW + 1);
  localparam int NarrW = 8;
  localparam int MidW  = 16;

  logic [IdxW-1:0]  widthBits;
  logic [IdxW-1:0]  msbIdx;
  logic [IdxW-1:0]  halfIdx;
  logic [DataW-1:0] sizeMask;
  logic [DataW-1:0] halfMask;
  logic [DataW-1:0] aMasked;
  logic [DataW-1:0] bMasked;
  logic             carryEff;
  logic [DataW:0]   wideSum;
  logic [DataW:0]   nibSum;
  logic [DataW-1:0] arithRes;
  logic             arithOvf;
  logic [DataW-1:0] bitRes;
  logic [DataW-1:0] rotRes;
  logic             rotCarry;

  // Width decode: the half boundary sits four bits below the top
  always_comb begin
    case (sizeSel)
      2'd0:    widthBits = IdxW'(NarrW);
      2'd1:    widthBits = IdxW'(MidW);
      default: widthBits = IdxW'(DataW);
    endcase
    msbIdx   = widthBits - IdxW'(1);
    halfIdx  = widthBits - IdxW'(4);
    sizeMask = (DataW'(1) << widthBits) - DataW'(1);
    halfMask = (DataW'(1) << halfIdx) - DataW'(1);
    aMasked  = opA & sizeMask;
    bMasked  = opB & sizeMask;
  end

  // Adder / subtractor, full and low-nibble-segment
  always_comb begin
    carryEff = strobe.useCarry & carryIn;
    if (strobe.doSub) begin
      wideSum = {1'b0, aMasked} - {1'b0, bMasked} - (DataW+1)'(carryEff);
      nibSum  = {1'b0, aMasked & halfMask} - {1'b0, bMasked & halfMask}
                - (DataW+1)'(carryEff);
    end else begin
      wideSum = {1'b0, aMasked} + {1'b0, bMasked} + (DataW+1)'(carryEff);
      nibSum  = {1'b0, aMasked & halfMask} + {1'b0, bMasked & halfMask}
                + (DataW+1)'(carryEff);
    end
    arithRes = wideSum[DataW-1:0] & sizeMask;
    if (strobe.doSub)
      arithOvf = (aMasked[msbIdx] != bMasked[msbIdx]) &&
                 (arithRes[msbIdx] != aMasked[msbIdx]);
    else
      arithOvf = (aMasked[msbIdx] == bMasked[msbIdx]) &&
                 (arithRes[msbIdx] != aMasked[msbIdx]);
  end

  // Bitwise unit
  always_comb begin
    case (strobe.bitOp)
      BitOr:   bitRes = aMasked | bMasked;
      BitXor:  bitRes = aMasked ^ bMasked;
      default: bitRes = aMasked & bMasked;
    endcase
  end

  // Rotate through carry
  always_comb begin
    if (strobe.rotRight) begin
      rotRes   = (aMasked >> 1) | (DataW'(carryIn) << msbIdx);
      rotCarry = aMasked[0];
    end else begin
      rotRes   = ((aMasked << 1) | DataW'(carryIn)) & sizeMask;
      rotCarry = aMasked[msbIdx];
    end
  end

  // Result select and flag assembly
  always_comb begin
    flags = '0;
    if (strobe.doBitwise) begin
      result       = bitRes;
      flags.half   = (strobe.bitOp == BitAnd);
      flags.parOvf = ~^bitRes;
    end else if (strobe.doRotate) begin
      result       = rotRes;
      flags.carry  = rotCarry;
      flags.parOvf = ~^rotRes;
    end else begin
      result       = arithRes;
      flags.carry  = wideSum[widthBits];
      flags.half   = nibSum[halfIdx];
      flags.parOvf = arithOvf;
      flags.subtr  = strobe.doSub;
    end
    flags.sign = result[msbIdx];
    flags.zero = (result == '0);
  end
endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
#(
  parameter int DataW = aluPkg::DataW,
  parameter int FlagW = aluPkg::FlagW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [1:0]       sizeSel,
  input  logic [3:0]       opCode,
  input  logic             carryIn,
  input  logic             flagWrEn,
  output logic [DataW-1:0] result,
  output logic [FlagW-1:0] flagsNow,
  output logic [FlagW-1:0] flagReg
);
  aluStrobeT strobe;
  flagT      pathFlags;
  logic      histValid;

  aluCtrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  aluPath #(.DataW(DataW)) uPath (
    .opA     (opA),
    .opB     (opB),
    .sizeSel (sizeSel),
    .carryIn (carryIn),
    .strobe  (strobe),
    .result  (result),
    .flags   (pathFlags)
  );

  assign flagsNow = FlagW'(pathFlags);

  always_ff @(posedge clk) begin
    if (rst)           flagReg <= '0;
    else if (flagWrEn) flagReg <= flagsNow;
  end

  always_ff @(posedge clk) begin
    if (rst) histValid <= 1'b0;
    else     histValid <= 1'b1;
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (histValid && !flagWrEn) |=> $stable(flagReg))
    else $error("flag register changed without write enable");

  assert_load_R12: assert property (@(posedge clk) disable iff (rst)
    (histValid && flagWrEn) |=> (flagReg == $past(flagsNow)))
    else $error("flag register missed a write");

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (sizeSel == 2'd0) |-> (result[DataW-1:8] == '0))
    else $error("result bits above byte width not zero");

  assert_bitwise_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (opCode inside {4'd4, 4'd5, 4'd6}) |-> (flagsNow[1:0] == 2'b00))
    else $error("bitwise op left carry or subtract set");

  assert_sub_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (opCode inside {4'd2, 4'd3}) |-> flagsNow[1])
    else $error("subtract flag clear on a subtract");

  assert_sign_mid_R9: assert property (@(posedge clk) disable iff (rst)
    (sizeSel == 2'd1) |-> (flagsNow[5] == result[15]))
    else $error("sign flag differs from bit 15");
endmodule

// File: tb/tb_aluFlagUnit.sv
module tb_aluFlagUnit;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [1:0]  sizeSel = '0;
  logic [3:0]  opCode = '0;
  logic        carryIn = 1'b0;
  logic        flagWrEn = 1'b0;
  logic [31:0] result;
  logic [5:0]  flagsNow;
  logic [5:0]  flagReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  aluFlagUnit dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .sizeSel(sizeSel),
    .opCode(opCode), .carryIn(carryIn), .flagWrEn(flagWrEn),
    .result(result), .flagsNow(flagsNow), .flagReg(flagReg)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirement text
  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sz, input logic [3:0] op,
                       input logic cin,
                       output logic [31:0] r, output logic [5:0] f);
    int w;
    longint m, hm, am, bm, sa, sb, sv, full, c, lim;
    logic s, z, h, pv, n, cy;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (64'sd1 <<< w) - 1;
    hm = (64'sd1 <<< (w - 4)) - 1;
    am = longint'(a) & m;
    bm = longint'(b) & m;
    lim = 64'sd1 <<< (w - 1);
    sa = (am >= lim) ? am - (64'sd1 <<< w) : am;
    sb = (bm >= lim) ? bm - (64'sd1 <<< w) : bm;
    c  = (op == 4'd1 || op == 4'd3) ? longint'(cin) : 0;
    h = 0; pv = 0; n = 0; cy = 0; full = 0;
    case (op)
      4'd2, 4'd3: begin
        full = (am - bm - c) & m;
        cy = am < bm + c;
        h  = (am & hm) < (bm & hm) + c;
        sv = sa - sb - c;
        pv = (sv >= lim) || (sv < -lim);
        n  = 1;
      end
      4'd4, 4'd5, 4'd6: begin
        full = (op == 4'd4) ? (am & bm) : (op == 4'd5) ? (am | bm) : (am ^ bm);
        h  = (op == 4'd4);
        pv = ($countones(full) % 2) == 0;
      end
      4'd7: begin
        full = ((am << 1) | longint'(cin)) & m;
        cy = (am >> (w - 1)) & 1;
        pv = ($countones(full) % 2) == 0;
      end
      4'd8: begin
        full = (am >> 1) | (longint'(cin) << (w - 1));
        cy = am & 1;
        pv = ($countones(full) % 2) == 0;
      end
      default: begin
        full = am + bm + c;
        cy = full > m;
        full = full & m;
        h  = (am & hm) + (bm & hm) + c > hm;
        sv = sa + sb + c;
        pv = (sv >= lim) || (sv < -lim);
      end
    endcase
    r = 32'(full);
    s = (full >> (w - 1)) & 1;
    z = (full == 0);
    f = {s, z, h, pv, n, cy};
  endtask

  task automatic runOp(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sz, input logic [3:0] op,
                       input logic cin, input string resTag);
    logic [31:0] er;
    logic [5:0]  ef;
    string cTag, pTag, hTag;
    @(negedge clk);
    opA = a; opB = b; sizeSel = sz; opCode = op; carryIn = cin;
    #1;
    model(a, b, sz, op, cin, er, ef);
    cTag = (op <= 4'd1) ? "R2" : (op <= 4'd3) ? "R3" : (op <= 4'd6) ? "R10" : "R11";
    pTag = (op <= 4'd3) ? "R5" : "R6";
    hTag = (op <= 4'd3) ? "R7" : (op <= 4'd6) ? "R10" : "R11";
    check(resTag, "result", longint'(result), longint'(er));
    check("R9", "sign", longint'(flagsNow[5]), longint'(ef[5]));
    check("R8", "zero", longint'(flagsNow[4]), longint'(ef[4]));
    check(hTag, "half", longint'(flagsNow[3]), longint'(ef[3]));
    check(pTag, "parOvf", longint'(flagsNow[2]), longint'(ef[2]));
    check("R4", "subtr", longint'(flagsNow[1]), longint'(ef[1]));
    check(cTag, "carry", longint'(flagsNow[0]), longint'(ef[0]));
  endtask

  task automatic testReset;
    check("R12", "flagReg after reset", longint'(flagReg), 0);
  endtask

  task automatic testAdd;
    runOp(32'h0F, 32'h01, 2'd0, 4'd0, 1'b0, "R2");       // half at 3->4
    runOp(32'h7F, 32'h01, 2'd0, 4'd0, 1'b0, "R2");       // signed overflow
    runOp(32'hFF, 32'h01, 2'd0, 4'd0, 1'b1, "R2");       // carry, zero, cin ignored
    runOp(32'h0FFF, 32'h1, 2'd1, 4'd0, 1'b0, "R2");      // half at 11->12
    runOp(32'h0FFFFFFF, 32'h1, 2'd2, 4'd0, 1'b0, "R2");  // half at 27->28
    runOp(32'hFFFFFFFF, 32'h1, 2'd3, 4'd0, 1'b0, "R2");  // 32-bit carry
    runOp(32'h7FFF, 32'h0001, 2'd1, 4'd0, 1'b0, "R2");   // 16-bit overflow
  endtask

  task automatic testAdc;
    runOp(32'h0E, 32'h01, 2'd0, 4'd1, 1'b1, "R2");       // cin reaches half
    runOp(32'h7E, 32'h01, 2'd0, 4'd1, 1'b1, "R2");       // cin causes overflow
    runOp(32'hFFFE, 32'h1, 2'd1, 4'd1, 1'b1, "R2");      // cin causes carry
  endtask

  task automatic testSub;
    runOp(32'h00, 32'h01, 2'd0, 4'd2, 1'b1, "R3");       // borrow, cin ignored
    runOp(32'h80, 32'h01, 2'd0, 4'd2, 1'b0, "R3");       // signed overflow
    runOp(32'h10, 32'h01, 2'd0, 4'd2, 1'b0, "R3");       // half borrow
    runOp(32'h1000, 32'h1, 2'd1, 4'd2, 1'b0, "R3");
    runOp(32'h10000000, 32'h1, 2'd2, 4'd2, 1'b0, "R3");
    runOp(32'h55, 32'h55, 2'd0, 4'd2, 1'b0, "R3");       // zero
  endtask

  task automatic testSbc;
    runOp(32'h05, 32'h05, 2'd0, 4'd3, 1'b1, "R3");       // borrow from cin
    runOp(32'h8000, 32'h0, 2'd1, 4'd3, 1'b1, "R3");      // overflow from cin
    runOp(32'h0, 32'h0, 2'd2, 4'd3, 1'b1, "R3");
  endtask

  task automatic testBitwise;
    runOp(32'hF0, 32'h3C, 2'd0, 4'd4, 1'b1, "R10");
    runOp(32'hF0, 32'h0F, 2'd0, 4'd4, 1'b0, "R10");      // zero, even parity
    runOp(32'h01, 32'h02, 2'd0, 4'd5, 1'b0, "R10");
    runOp(32'h8001, 32'h0100, 2'd1, 4'd5, 1'b0, "R10");  // odd parity
    runOp(32'hAAAA5555, 32'hFFFF0000, 2'd2, 4'd6, 1'b0, "R10");
  endtask

  task automatic testRotate;
    runOp(32'h81, 32'h0, 2'd0, 4'd7, 1'b0, "R11");
    runOp(32'h40, 32'h0, 2'd0, 4'd7, 1'b1, "R11");
    runOp(32'h01, 32'h0, 2'd0, 4'd8, 1'b1, "R11");
    runOp(32'h8000, 32'h0, 2'd1, 4'd7, 1'b0, "R11");
    runOp(32'h00000001, 32'h0, 2'd2, 4'd8, 1'b0, "R11");
    runOp(32'h80000000, 32'h0, 2'd2, 4'd7, 1'b1, "R11");
  endtask

  task automatic testWidthMask;
    runOp(32'hABCD_12F0, 32'h5555_0010, 2'd0, 4'd0, 1'b0, "R1");
    runOp(32'hFFFF_0001, 32'hFFFF_0002, 2'd1, 4'd2, 1'b0, "R1");
    runOp(32'h1234_5681, 32'h0, 2'd0, 4'd7, 1'b0, "R1");
    runOp(32'hFF00_00FF, 32'hFF00_0F0F, 2'd0, 4'd6, 1'b0, "R1");
  endtask

  task automatic testFlagReg;
    @(negedge clk);
    opA = 32'hFF; opB = 32'h01; sizeSel = 2'd0; opCode = 4'd0;
    carryIn = 1'b0; flagWrEn = 1'b1;
    @(negedge clk);
    check("R12", "flagReg load", longint'(flagReg), longint'(6'b011001));
    flagWrEn = 1'b0; opA = 32'h00; opCode = 4'd2;
    @(negedge clk);
    check("R12", "flagReg hold", longint'(flagReg), longint'(6'b011001));
    flagWrEn = 1'b1;
    @(negedge clk);
    check("R12", "flagReg reload", longint'(flagReg), longint'(6'b101011));
    rst = 1'b1;
    @(negedge clk);
    check("R12", "reset wins over enable", longint'(flagReg), 0);
    rst = 1'b0; flagWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testAdd();
    testAdc();
    testSub();
    testSbc();
    testBitwise();
    testRotate();
    testWidthMask();
    testFlagReg();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule